// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the control section of a small single-bus processor. A step counter walks through numbered control steps, and the strobes that drive the datapath are formed directly as sum-of-products terms. Each term combines the current step with the instruction class lines and the condition flag. The strobes cover register gating onto and off the bus, the memory address latch, the memory read request, the ALU add operation, the select that picks the constant 4 or the Y register for the ALU's first operand, and the PC load. The register file, ALU and memory sit outside the block.

Every instruction starts with three fetch steps. The instruction decoder outside the block then supplies one of three class lines: register-indirect add, unconditional branch, or branch-if-negative. Steps from 4 onward follow that class. At steps that wait for memory, the counter stops until the memory-complete input goes high. A single-cycle end pulse closes each instruction and sends the counter back to step 1.

Top module: `stepctl_hw`

## Requirements
- R1: While `rst` is high, every strobe output including `end_pulse` is 0. In the first cycle after `rst` falls, the step-1 strobes appear.
- R2: Step 1 asserts `pc_out`, `mar_in`, `mem_read`, `mux_const` (1 = constant 4 feeds the ALU, 0 = Y feeds it), `alu_add` and `z_in`, and nothing else.
- R3: Step 2 asserts `z_out`, `pc_in` and `y_in`. While `mfc` is low the step does not advance and the strobes stay the same. The cycle in which `mfc` is high is the last cycle of step 2.
- R4: Step 3 asserts `mdr_out` and `ir_in` only.
- R5: Add class (`cls_add`=1) runs four more steps. Step 4 asserts `ra_out`, `mar_in` and `mem_read`. Step 5 asserts `rb_out` and `y_in`, and waits for `mfc` in the same way as step 2. Step 6 asserts `mdr_out`, `alu_add` and `z_in`, with `mux_const`=0. Step 7 asserts `z_out`, `rd_in` and `end_pulse`.
- R6: Unconditional branch class (`cls_br`=1, `cls_add`=0) runs two more steps. Step 4 asserts `off_out`, `alu_add` and `z_in`. Step 5 asserts `z_out`, `pc_in` and `end_pulse`.
- R7: Conditional branch class (`cls_brn`=1, other class lines 0) behaves as R6 when `flag_n`=1. When `flag_n`=0 it asserts only `end_pulse` at step 4, and `pc_in` stays 0.
- R8: `z_in` is high only at step 1, at step 6 of an add, and at step 4 of a taken branch.
- R9: `end_pulse` lasts one cycle, and the next cycle (outside reset) shows the step-1 strobes.
- R10: Class priority is add over unconditional branch over conditional branch. With no class line high, step 4 asserts only `end_pulse`.
- R11: At most one of the bus drivers `pc_out`, `z_out`, `mdr_out`, `off_out`, `ra_out`, `rb_out` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cls_add | input | 1 | Instruction class: register-indirect add |
| cls_br | input | 1 | Instruction class: unconditional branch |
| cls_brn | input | 1 | Instruction class: branch if negative |
| flag_n | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory function complete |
| pc_out | output | 1 | PC drives bus |
| pc_in | output | 1 | PC loads from bus |
| mar_in | output | 1 | Memory address register loads |
| mem_read | output | 1 | Memory read request |
| mux_const | output | 1 | ALU first operand: 1 constant 4, 0 Y |
| alu_add | output | 1 | ALU performs add |
| z_in | output | 1 | Z register loads ALU result |
| z_out | output | 1 | Z drives bus |
| y_in | output | 1 | Y register loads from bus |
| mdr_out | output | 1 | Memory data register drives bus |
| ir_in | output | 1 | Instruction register loads |
| off_out | output | 1 | IR offset field drives bus |
| ra_out | output | 1 | Source address register drives bus |
| rb_out | output | 1 | Second operand register drives bus |
| rd_in | output | 1 | Destination register loads |
| end_pulse | output | 1 | Instruction finished |

## Verification
The bench varies how long `mfc` stays low at both wait steps. A counter that leaks past a wait would shift every later strobe by one step, and a counter that never leaves the wait would starve the next fetch. It runs every combination of the three class lines with both flag values, so a wrong priority or a taken path on a failed test shows up as a stray `pc_in` or a missing early `end_pulse`. A reset in the middle of an instruction checks that the sequence restarts cleanly at step 1 and is not picked up where it left off.

// File: rtl/stepctl_hw.sv
module stepctl_hw (
  input  logic clk,
  input  logic rst,
  input  logic cls_add,
  input  logic cls_br,
  input  logic cls_brn,
  input  logic flag_n,
  input  logic mfc,
  output logic pc_out,
  output logic pc_in,
  output logic mar_in,
  output logic mem_read,
  output logic mux_const,
  output logic alu_add,
  output logic z_in,
  output logic z_out,
  output logic y_in,
  output logic mdr_out,
  output logic ir_in,
  output logic off_out,
  output logic ra_out,
  output logic rb_out,
  output logic rd_in,
  output logic end_pulse
);
  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

  logic [STEP_W-1:0] step_q;
  logic t1, t2, t3, t4, t5, t6, t7;
  logic k_add, k_br, k_skip, k_none, live;
  logic wait_mfc, overrun;

  assign t1 = step_q == 3'd1;
  assign t2 = step_q == 3'd2;
  assign t3 = step_q == 3'd3;
  assign t4 = step_q == 3'd4;
  assign t5 = step_q == 3'd5;
  assign t6 = step_q == 3'd6;
  assign t7 = step_q == 3'd7;

  assign k_add  = cls_add;
  assign k_br   = !cls_add && (cls_br || (cls_brn && flag_n));
  assign k_skip = !cls_add && !cls_br && cls_brn && !flag_n;
  assign k_none = !cls_add && !cls_br && !cls_brn;
  assign live   = !rst;

  assign pc_out    = live & t1;
  assign mar_in    = live & (t1 | (t4 & k_add));
  assign mem_read  = live & (t1 | (t4 & k_add));
  assign mux_const = live & t1;
  assign alu_add   = live & (t1 | (t6 & k_add) | (t4 & k_br));
  assign z_in      = live & (t1 | (t6 & k_add) | (t4 & k_br));
  assign z_out     = live & (t2 | (t7 & k_add) | (t5 & k_br));
  assign pc_in     = live & (t2 | (t5 & k_br));
  assign y_in      = live & (t2 | (t5 & k_add));
  assign mdr_out   = live & (t3 | (t6 & k_add));
  assign ir_in     = live & t3;
  assign off_out   = live & t4 & k_br;
  assign ra_out    = live & t4 & k_add;
  assign rb_out    = live & t5 & k_add;
  assign rd_in     = live & t7 & k_add;
  assign end_pulse = live & ((t7 & k_add) | (t5 & k_br) | (t4 & (k_skip | k_none)));

  assign wait_mfc = t2 | (t5 & k_add);
  assign overrun  = (step_q == '0) | (t5 & !k_add & !k_br) | ((t6 | t7) & !k_add);

  always_ff @(posedge clk) begin
    if (rst)                       step_q <= FIRST;
    else if (end_pulse || overrun) step_q <= FIRST;
    else if (wait_mfc && !mfc)     step_q <= step_q;
    else                           step_q <= step_q + STEP_W'(1);
  end
endmodule

// File: rtl/stepctl_hw_chk.sv
module stepctl_hw_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] step_q,
  input logic       wait_mfc,
  input logic       mfc,
  input logic       end_pulse,
  input logic       pc_in,
  input logic       cls_add,
  input logic       cls_br,
  input logic       cls_brn,
  input logic       flag_n,
  input logic [5:0] bus,
  input logic [15:0] strobes
);
  always_comb begin
    if (rst) a_r1_quiet_in_reset: assert (strobes == 16'd0);
  end

  always_comb begin
    a_r11_single_driver: assert ($onehot0(bus));
  end

  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (wait_mfc && !mfc) |=> $stable(step_q));

  a_r2_fetch_advances: assert property (@(posedge clk) disable iff (rst)
    (step_q == 3'd1 || step_q == 3'd3) |=> (step_q == $past(step_q) + 3'd1));

  a_r9_restart_after_end: assert property (@(posedge clk) disable iff (rst)
    end_pulse |=> (step_q == 3'd1));

  a_r9_end_one_cycle: assert property (@(posedge clk) disable iff (rst)
    end_pulse |=> !end_pulse);

  a_r7_failed_test_no_pc: assert property (@(posedge clk) disable iff (rst)
    (step_q >= 3'd4 && cls_brn && !cls_br && !cls_add && !flag_n) |-> !pc_in);
endmodule

bind stepctl_hw stepctl_hw_chk u_chk (
  .clk(clk), .rst(rst), .step_q(step_q), .wait_mfc(wait_mfc), .mfc(mfc),
  .end_pulse(end_pulse), .pc_in(pc_in), .cls_add(cls_add), .cls_br(cls_br),
  .cls_brn(cls_brn), .flag_n(flag_n),
  .bus({pc_out, z_out, mdr_out, off_out, ra_out, rb_out}),
  .strobes({pc_out, pc_in, mar_in, mem_read, mux_const, alu_add, z_in, z_out,
            y_in, mdr_out, ir_in, off_out, ra_out, rb_out, rd_in, end_pulse})
);

// File: tb/stepctl_hw_tb.sv
`timescale 1ns/1ps
module stepctl_hw_tb;
  logic clk = 0, rst = 1;
  logic cls_add = 0, cls_br = 0, cls_brn = 0, flag_n = 0, mfc = 0;
  logic pc_out, pc_in, mar_in, mem_read, mux_const, alu_add, z_in, z_out;
  logic y_in, mdr_out, ir_in, off_out, ra_out, rb_out, rd_in, end_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stepctl_hw u_dut (.*);

  localparam logic [15:0] S_PCO = 16'h8000, S_PCI = 16'h4000, S_MAR = 16'h2000,
    S_RD = 16'h1000, S_C4 = 16'h0800, S_ADD = 16'h0400, S_ZI = 16'h0200,
    S_ZO = 16'h0100, S_YI = 16'h0080, S_MDR = 16'h0040, S_IR = 16'h0020,
    S_OFF = 16'h0010, S_RA = 16'h0008, S_RB = 16'h0004, S_RDI = 16'h0002,
    S_END = 16'h0001;

  // path: 0 add, 1 branch taken, 2 failed conditional test, 3 no class
  function automatic int path_of(bit a, bit b, bit c, bit n);
    if (a) return 0;
    if (b) return 1;
    if (c) return n ? 1 : 2;
    return 3;
  endfunction

  function automatic logic [15:0] expect_vec(int s, int p, bit r);
    if (r) return 16'h0;
    case (s)
      1: return S_PCO | S_MAR | S_RD | S_C4 | S_ADD | S_ZI;
      2: return S_ZO | S_PCI | S_YI;
      3: return S_MDR | S_IR;
      default: ;
    endcase
    case (p)
      0: case (s)
           4: return S_RA | S_MAR | S_RD;
           5: return S_RB | S_YI;
           6: return S_MDR | S_ADD | S_ZI;
           default: return S_ZO | S_RDI | S_END;
         endcase
      1: return (s == 4) ? (S_OFF | S_ADD | S_ZI) : (S_ZO | S_PCI | S_END);
      default: return S_END;
    endcase
  endfunction

  function automatic string req_of(int s, int p, bit r, bit c);
    if (r) return "R1";
    if (s == 1) return "R2";
    if (s == 2) return "R3";
    if (s == 3) return "R4";
    if (p == 0) return "R5";
    if (p == 3) return "R10";
    if (c && p != 0) return "R7";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int mstep = 1, ic = 0, wcnt = 0, p = 3;
    bit prev_end = 0, pure_brn;
    logic [15:0] act, exp;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      rst = (cyc < 3) || (cyc >= 3000 && cyc < 3003);
      if (mstep == 1) begin
        ic++;
        {cls_add, cls_br, cls_brn} = 3'(ic);
        flag_n = ic[3];
        wcnt = 0;
      end
      p = path_of(cls_add, cls_br, cls_brn, flag_n);
      pure_brn = cls_brn && !cls_add && !cls_br;
      if (mstep == 2 || (mstep == 5 && p == 0)) begin
        if (cyc < 2500) mfc = (wcnt >= (ic % 4));
        else mfc = ($urandom_range(0, 2) == 0);
      end else mfc = ic[0];
      #1;
      act = {pc_out, pc_in, mar_in, mem_read, mux_const, alu_add, z_in, z_out,
             y_in, mdr_out, ir_in, off_out, ra_out, rb_out, rd_in, end_pulse};
      exp = expect_vec(mstep, p, rst);
      check(act == exp, req_of(mstep, p, rst, pure_brn), act, exp);
      // R8: z_in formula from the step and class
      check(z_in == (!rst && (mstep == 1 || (mstep == 6 && p == 0) || (mstep == 4 && p == 1))),
            "R8", 16'(z_in), exp & S_ZI);
      // R11: single bus driver
      check($countones({pc_out, z_out, mdr_out, off_out, ra_out, rb_out}) <= 1, "R11",
            16'({pc_out, z_out, mdr_out, off_out, ra_out, rb_out}), 16'h0);
      // R9: cycle after end shows fetch
      if (prev_end && !rst)
        check(pc_out && mar_in && !end_pulse, "R9", act, expect_vec(1, p, 0));
      prev_end = end_pulse;
      // reference model step update
      if (rst) mstep = 1;
      else if ((exp & S_END) != 0) mstep = 1;
      else if ((mstep == 2 || (mstep == 5 && p == 0)) && !mfc) begin
        mstep = mstep; wcnt++;
      end else begin
        mstep++; wcnt = 0;
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule